// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one asynchronous interrupt pin and turns it into a latched interrupt flag and a gated interrupt request. The pin first passes through a synchronizer. The block then compares the result with a programmable asserted level. A rising transition into the asserted level sets the flag. Software clears the flag with a one-cycle acknowledge strobe.

A mode select picks how the flag behaves. In edge-only mode, a transition sets the flag and an acknowledge clears it. In edge-and-level mode, the flag is still set only by a transition, but it is held set while the pin stays asserted. An acknowledge in that state does nothing.

The block also reports the pin state, expressed relative to the chosen polarity. It drives the pad's internal pull device as well. The pull is switched on when the pin function is enabled and the pull has not been disabled. It always pulls toward the deasserted level.

Top module: `eip_detector`

## Requirements
- R1: `pin_raw` passes through `SYNC_STAGES` flops (default 2). With `pin_en`, `pol_high` and `lvl_mode` held, a change of `pin_raw` captured at rising edge k sets `flag` after rising edge k+`SYNC_STAGES`, and not before.
- R2: `pull_en` is 1 exactly when `pin_en` is 1 and `pull_dis` is 0.
- R3: `pull_up` is the inverse of `pol_high`, so the pull always goes toward the deasserted level. `pol_high`=1 means the high level is asserted.
- R4: `flag` is set when the synchronized pin moves from the deasserted level to the asserted level while the configuration is unchanged.
- R5: In edge-only mode (`lvl_mode`=0), `flag_ack`=1 clears `flag` at the next edge. If a setting transition is detected in the same cycle, the set wins.
- R6: In edge-and-level mode (`lvl_mode`=1), a set `flag` stays set while the synchronized pin is at the asserted level, and `flag_ack` is ignored. Once the pin is deasserted, `flag_ack` clears it.
- R7: `pin_stat` is 1 when `pin_en`=1 and the synchronized pin equals the asserted level. Otherwise it is 0.
- R8: `irq_req` is 1 exactly when `flag`=1 and `irq_en`=1.
- R9: In a cycle where `pin_en`, `pol_high` or `lvl_mode` differs from its value in the previous cycle, no transition is detected. This covers a polarity flip that makes the pin appear newly asserted.
- R10: While `pin_en`=0, `flag` is cleared at the next edge and stays 0.
- R11: After reset, `flag` and `irq_req` are 0, the synchronizer holds 0, and the transition history reads as already asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Asynchronous external pin |
| pin_en | input | 1 | Enables the pin function |
| pol_high | input | 1 | 1: asserted high, 0: asserted low |
| lvl_mode | input | 1 | 0: edge-only, 1: edge-and-level |
| irq_en | input | 1 | Local interrupt enable |
| pull_dis | input | 1 | 1 turns the internal pull off |
| flag_ack | input | 1 | One-cycle flag clear strobe |
| flag | output | 1 | Latched interrupt flag |
| irq_req | output | 1 | Interrupt request |
| pin_stat | output | 1 | Pin is at its asserted level |
| pull_en | output | 1 | Pad pull device on |
| pull_up | output | 1 | Pull direction, 1 = up |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the very cycle a new asserting transition is detected. The acknowledge must arrive exactly `SYNC_STAGES` edges after the pin changes. A second hard case is a polarity or mode change that lands on a pin that would otherwise look newly asserted. Directed sequences count edges from the pin change to place the acknowledge and the polarity flip in exactly those cycles. Seeded random stimulus then toggles the pin, the acknowledge and the configuration at low rates, and each cycle is compared against a bench model built from the requirements.

// File: rtl/eip_pkg.sv
package eip_pkg;
   typedef enum logic {
      DET_EDGE       = 1'b0,
      DET_EDGE_LEVEL = 1'b1
   } det_mode_e;

   typedef struct packed {
      logic      en;
      logic      pol;
      det_mode_e mode;
   } pin_cfg_t;
endpackage

// File: rtl/eip_sync.sv
module eip_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad
      $error("eip_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[i] <= RST_VAL;
         else if (i == 0) chain[i] <= d;
         else             chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eip_hist.sv
module eip_hist
   import eip_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg,
   input  logic     lvl_q,
   output logic     act,
   output logic     rise
);
   logic     act_d;
   pin_cfg_t cfg_q;
   logic     cfg_chg;

   assign act     = cfg.en & (lvl_q == cfg.pol);
   assign cfg_chg = (cfg != cfg_q);
   assign rise    = act & ~act_d & ~cfg_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d <= 1'b1;
         cfg_q <= '0;
      end else begin
         act_d <= act;
         cfg_q <= cfg;
      end
   end
endmodule

// File: rtl/eip_flag.sv
module eip_flag
   import eip_pkg::*;
#(
   parameter bit LEVEL_SUPPORT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  det_mode_e mode,
   input  logic      rise,
   input  logic      act,
   input  logic      ack,
   output logic      flag
);
   logic hold;
   logic flag_nxt;

   if (LEVEL_SUPPORT) begin : g_lvl
      assign hold = (mode == DET_EDGE_LEVEL) & act & flag;
   end else begin : g_nolvl
      logic unused_lvl;
      assign unused_lvl = (mode == DET_EDGE_LEVEL) ^ act;
      assign hold = 1'b0;
   end

   always_comb begin
      if (!en)       flag_nxt = 1'b0;
      else if (rise) flag_nxt = 1'b1;
      else if (hold) flag_nxt = 1'b1;
      else if (ack)  flag_nxt = 1'b0;
      else           flag_nxt = flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag_nxt;
   end
endmodule

// File: rtl/eip_detector.sv
module eip_detector
   import eip_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit LEVEL_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   input  logic pin_en,
   input  logic pol_high,
   input  logic lvl_mode,
   input  logic irq_en,
   input  logic pull_dis,
   input  logic flag_ack,
   output logic flag,
   output logic irq_req,
   output logic pin_stat,
   output logic pull_en,
   output logic pull_up
);
   pin_cfg_t cfg;
   logic     pin_q;
   logic     rise;

   assign cfg.en   = pin_en;
   assign cfg.pol  = pol_high;
   assign cfg.mode = det_mode_e'(lvl_mode);

   eip_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_q)
   );

   eip_hist u_hist (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .lvl_q(pin_q),
      .act(pin_stat), .rise(rise)
   );

   eip_flag #(.LEVEL_SUPPORT(LEVEL_SUPPORT)) u_flag (
      .clk(clk), .rst_n(rst_n), .en(pin_en), .mode(cfg.mode),
      .rise(rise), .act(pin_stat), .ack(flag_ack), .flag(flag)
   );

   assign irq_req = flag & irq_en;
   assign pull_en = pin_en & ~pull_dis;
   assign pull_up = ~pol_high;
endmodule

// File: rtl/eip_detector_chk.sv
module eip_detector_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_en,
   input logic pol_high,
   input logic lvl_mode,
   input logic irq_en,
   input logic pull_dis,
   input logic flag_ack,
   input logic flag,
   input logic irq_req,
   input logic pin_stat,
   input logic pull_en,
   input logic pull_up
);
   p_req_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flag && irq_en));

   p_pull_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pull_en |-> (pin_en && !pull_dis));

   p_pull_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pull_en |-> (pull_up != pol_high));

   p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && pin_en && pin_stat && !$past(pin_stat) &&
       $stable(pol_high) && $stable(lvl_mode) && $stable(pin_en)) |=> flag);

   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en && !lvl_mode && flag_ack && !pin_stat) |=> !flag);

   p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en && lvl_mode && pin_stat && flag) |=> flag);

   p_stat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |-> !pin_stat);

   p_disable_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |=> !flag);
endmodule

bind eip_detector eip_detector_chk u_chk (.*);

// File: tb/tb_eip_detector.sv
module tb_eip_detector;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_raw = 1'b0, pin_en = 1'b0, pol_high = 1'b1, lvl_mode = 1'b0;
   logic irq_en = 1'b0, pull_dis = 1'b0, flag_ack = 1'b0;
   logic flag, irq_req, pin_stat, pull_en, pull_up;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model state
   logic [SYNC-1:0] m_s;
   logic m_ad, m_flag;
   logic [2:0] m_cfg;

   always #5 clk = ~clk;

   eip_detector #(.SYNC_STAGES(SYNC)) dut (.*);

   function automatic logic m_act();
      return pin_en && (m_s[SYNC-1] == pol_high);
   endfunction

   task automatic model_step();
      logic a, chg, rise, nf;
      a    = m_act();
      chg  = ({pin_en, pol_high, lvl_mode} != m_cfg);
      rise = a && !m_ad && !chg;
      if (!pin_en)                       nf = 1'b0;
      else if (rise)                     nf = 1'b1;
      else if (lvl_mode && a && m_flag)  nf = 1'b1;
      else if (flag_ack)                 nf = 1'b0;
      else                               nf = m_flag;
      m_flag = nf;
      m_ad   = a;
      m_cfg  = {pin_en, pol_high, lvl_mode};
      m_s    = {m_s[SYNC-2:0], pin_raw};
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      chk(flag,     m_flag,                "R4/R5/R6 flag");
      chk(irq_req,  m_flag && irq_en,      "R8 irq_req");
      chk(pin_stat, m_act(),               "R7 pin_stat");
      chk(pull_en,  pin_en && !pull_dis,   "R2 pull_en");
      chk(pull_up,  !pol_high,             "R3 pull_up");
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cmp_all();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      m_s = '0; m_ad = 1'b1; m_flag = 1'b0; m_cfg = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(flag, 1'b0, "R11 flag in reset");
      chk(irq_req, 1'b0, "R11 irq in reset");
      rst_n = 1'b1;
      pin_en = 1'b1; irq_en = 1'b1;
      ticks(4);

      // R2 / R3: pull control
      pull_dis = 1'b1; @(negedge clk); #1;
      chk(pull_en, 1'b0, "R2 pull off when disabled");
      pull_dis = 1'b0; pol_high = 1'b1; #1;
      chk(pull_up, 1'b0, "R3 pull down for high polarity");
      ticks(2);

      // R1 latency + R4 set
      pin_raw = 1'b1;
      tick(); chk(flag, 1'b0, "R1 after edge 1");
      tick(); chk(flag, 1'b0, "R1 after edge 2");
      tick(); chk(flag, 1'b1, "R1 R4 after edge 3");
      chk(irq_req, 1'b1, "R8 req with enable");
      irq_en = 1'b0; #1; chk(irq_req, 1'b0, "R8 req masked");
      irq_en = 1'b1;

      // R5: ack coincident with new edge, set wins
      pin_raw = 1'b0; ticks(4);
      pin_raw = 1'b1; tick(); tick();
      flag_ack = 1'b1; tick(); flag_ack = 1'b0;
      chk(flag, 1'b1, "R5 set wins over ack");
      flag_ack = 1'b1; tick(); flag_ack = 1'b0;
      chk(flag, 1'b0, "R5 ack clears edge flag");
      pin_raw = 1'b0; ticks(3);

      // R6: level mode hold
      lvl_mode = 1'b1; ticks(2);
      pin_raw = 1'b1; ticks(3);
      chk(flag, 1'b1, "R6 set in level mode");
      flag_ack = 1'b1; tick(); flag_ack = 1'b0;
      chk(flag, 1'b1, "R6 ack ignored while asserted");
      pin_raw = 1'b0; ticks(3);
      chk(flag, 1'b1, "R6 held after deassert");
      flag_ack = 1'b1; tick(); flag_ack = 1'b0;
      chk(flag, 1'b0, "R6 ack clears after deassert");

      // R9: polarity flip makes pin look asserted, no edge
      lvl_mode = 1'b0; ticks(2);
      pol_high = 1'b0; tick();
      chk(pin_stat, 1'b1, "R9 pin asserted after flip");
      ticks(2);
      chk(flag, 1'b0, "R9 no false edge");

      // R10: disable clears
      pin_raw = 1'b1; ticks(3);
      pin_raw = 1'b0; ticks(3);
      chk(flag, 1'b1, "R10 precondition flag set");
      pin_en = 1'b0; tick();
      chk(flag, 1'b0, "R10 disable clears flag");
      chk(pin_stat, 1'b0, "R7 stat off when disabled");
      pin_raw = 1'b1; ticks(3); pin_raw = 1'b0; ticks(3);
      chk(flag, 1'b0, "R10 stays clear while disabled");
      pin_en = 1'b1; ticks(2);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 5) == 0)   pin_raw  = ~pin_raw;
         flag_ack = ($urandom_range(0, 7) == 0);
         irq_en   = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 60) == 0)  pol_high = ~pol_high;
         if ($urandom_range(0, 60) == 0)  lvl_mode = ~lvl_mode;
         if ($urandom_range(0, 90) == 0)  pin_en   = ~pin_en;
         if ($urandom_range(0, 30) == 0)  pull_dis = ~pull_dis;
         tick();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule